// File: doc/BRIEF.md
# Transmit Flow Control Command Unit

This block sits on one serial channel between the transmit FIFO and the transmit shift register. It decides, cycle by cycle, whether the shifter may take a new character, and which character that is. It also carries out the host commands for software flow control. The host can queue an Xon or Xoff character for sending. It can halt the flow of FIFO data between characters and resume it. It can also withdraw a flow character that has not yet reached the shifter.

The FIFO is assumed to be show-ahead: `fifo_data` is valid whenever `fifo_nonempty` is high, and `fifo_pop` removes that word. The shifter raises `shifter_busy` in the cycle after it sees `shift_load` and holds it until the stop bit has gone out. The unit never loads while the shifter is busy, so a halt never cuts a frame short.

Load timing works as follows. The decision for a load is taken at a clock edge. It uses the pending state and halt state held before that edge, together with the inputs sampled at that edge. `shift_load`, `shift_data` and `fifo_pop` come from registers and appear after that edge. A command presented at the same edge updates the state, and the update takes effect from the next decision onward.

Top module: `txflow_ctrl`

## Requirements
- R1: A synchronous active-low reset drives `shift_load` and `fifo_pop` low. It also clears the halt state and any pending flow character.
- R2: Command code 5'b01111 queues an Xon. At the next load opportunity, `shift_load` pulses with `shift_data` equal to `xon_char` as sampled at the deciding edge, and `fifo_pop` stays low.
- R3: Command code 5'b10000 queues an Xoff. At the next load opportunity, `shift_load` pulses with `shift_data` equal to `xoff_char` as sampled at the deciding edge, and `fifo_pop` stays low.
- R4: When a flow character is pending and the FIFO also holds data, the flow character is loaded first.
- R5: Command code 5'b10110 halts the transfer of FIFO data. While the halt is in effect, `fifo_pop` stays low and no FIFO character is loaded.
- R6: A pending flow character is still loaded while the halt is in effect.
- R7: Command code 5'b10101 ends the halt when `auto_tx_mode` is low, and FIFO data then moves again. When `auto_tx_mode` is high, this command has no effect.
- R8: Command code 5'b10117 is not a valid code; the withdraw command is 5'b10111. It removes a pending flow character that has not been loaded. It has no effect when nothing is pending, or when the flow character is being loaded at the same edge.
- R9: A new Xon or Xoff command replaces a flow character that is still pending.
- R10: A load opportunity exists at an edge where `shifter_busy` is low and no load was issued at the previous edge. `shift_load` is then a one-cycle pulse. `fifo_pop` is high only together with a `shift_load` that carries FIFO data, in which case `shift_data` equals `fifo_data`.
- R11: Every other command code, and any code presented while `cmd_valid` is low, leaves the halt state and the pending flow character unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 5 | Command code |
| auto_tx_mode | input | 1 | Automatic transmit flow mode; blocks the resume command |
| xon_char | input | DATA_W | Value sent for an Xon |
| xoff_char | input | DATA_W | Value sent for an Xoff |
| fifo_nonempty | input | 1 | Transmit FIFO holds at least one character |
| fifo_data | input | DATA_W | Character at the FIFO head |
| fifo_pop | output | 1 | Removes the FIFO head character |
| shifter_busy | input | 1 | Shift register is sending a frame |
| shift_load | output | 1 | Load strobe to the shift register |
| shift_data | output | DATA_W | Character being loaded |

## Verification
The bench builds the block with the default character width of 8. This lets random values cover the whole Xon, Xoff and FIFO character space, so a wrong source selection at load time shows up as a data mismatch. Directed sequences first place commands against a busy shifter and against a load at the same edge. These cover the cases where a flow character and FIFO data compete, and where a withdraw races the load. A long random phase then mixes reserved codes, auto-mode toggling and irregular shifter busy patterns.

Note on R8: the withdraw command code is 5'b10111.

// File: rtl/txf_pkg.sv
// Shared command codes, flow kinds and decoded operation type for the
// transmit flow control unit.
package txf_pkg;

    localparam int CMD_W = 5;

    // Command codes understood by the unit; every other code is ignored.
    localparam logic [CMD_W-1:0] CMD_SEND_XON  = 5'b01111;
    localparam logic [CMD_W-1:0] CMD_SEND_XOFF = 5'b10000;
    localparam logic [CMD_W-1:0] CMD_RESUME    = 5'b10101;
    localparam logic [CMD_W-1:0] CMD_HALT      = 5'b10110;
    localparam logic [CMD_W-1:0] CMD_WITHDRAW  = 5'b10111;

    typedef enum logic [1:0] {
        FLOW_NONE = 2'd0,
        FLOW_ON   = 2'd1,
        FLOW_OFF  = 2'd2
    } flow_kind_e;

    typedef struct packed {
        logic send_on;
        logic send_off;
        logic resume;
        logic halt;
        logic withdraw;
    } txf_op_t;

endpackage

// File: rtl/txf_cmd_decode.sv
// Command decoder.
// Turns a strobed command code into at most one operation flag.
// Assumes: one command per strobe; the resume command is suppressed
// while automatic transmit flow mode is active.
module txf_cmd_decode
    import txf_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             auto_tx_mode,
    output txf_op_t          op
);

    // Decode the strobed code into operation flags.
    always_comb begin
        op = '0;
        if (cmd_valid) begin
            case (cmd_code)
                CMD_SEND_XON:  op.send_on  = 1'b1;
                CMD_SEND_XOFF: op.send_off = 1'b1;
                CMD_RESUME:    op.resume   = ~auto_tx_mode;
                CMD_HALT:      op.halt     = 1'b1;
                CMD_WITHDRAW:  op.withdraw = 1'b1;
                default:       op = '0;
            endcase
        end
    end

endmodule

// File: rtl/txf_flow_queue.sv
// Pending flow character holder.
// Remembers which flow character (if any) is waiting for the shifter.
// Assumes: flow_taken pulses at the edge where the arbiter loads the
// pending character; a command at that edge acts after the removal.
module txf_flow_queue
    import txf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  txf_op_t    op,
    input  logic       flow_taken,
    output flow_kind_e pend_kind
);

    flow_kind_e pend_next;

    // Next pending kind: removal by load first, then the command.
    always_comb begin
        pend_next = pend_kind;
        if (flow_taken)
            pend_next = FLOW_NONE;
        if (op.send_on)
            pend_next = FLOW_ON;
        else if (op.send_off)
            pend_next = FLOW_OFF;
        else if (op.withdraw)
            pend_next = FLOW_NONE;
    end

    // Pending kind register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_kind <= FLOW_NONE;
        else
            pend_kind <= pend_next;
    end

endmodule

// File: rtl/txf_halt_ctrl.sv
// Host halt flag.
// Set by the halt command, cleared by an (already mode-gated) resume.
// Assumes: halt and resume never arrive in the same cycle.
module txf_halt_ctrl
    import txf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  txf_op_t op,
    output logic    halt_q
);

    // Halt flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (op.halt)
            halt_q <= 1'b1;
        else if (op.resume)
            halt_q <= 1'b0;
    end

endmodule

// File: rtl/txf_load_arb.sv
// Shifter load arbiter.
// Picks the pending flow character ahead of FIFO data and registers the
// load strobe, data and FIFO pop.
// Assumes: the shifter raises busy the cycle after a load, so one guard
// cycle after each load stops a second load into a shifter that is busy
// but has not said so yet.
module txf_load_arb
    import txf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  flow_kind_e        pend_kind,
    input  logic              halt_q,
    input  logic              fifo_nonempty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [DATA_W-1:0] xon_char,
    input  logic [DATA_W-1:0] xoff_char,
    input  logic              shifter_busy,
    output logic              flow_taken,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data,
    output logic              fifo_pop
);

    logic              ready;
    logic              take_data;
    logic [DATA_W-1:0] pick;

    // Decide the load source for this edge.
    always_comb begin
        ready      = ~shifter_busy & ~shift_load;
        flow_taken = ready & (pend_kind != FLOW_NONE);
        take_data  = ready & ~flow_taken & ~halt_q & fifo_nonempty;
        case (pend_kind)
            FLOW_ON:  pick = xon_char;
            FLOW_OFF: pick = xoff_char;
            default:  pick = fifo_data;
        endcase
    end

    // Register the load strobe, pop and character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_load <= 1'b0;
            fifo_pop   <= 1'b0;
            shift_data <= '0;
        end else begin
            shift_load <= flow_taken | take_data;
            fifo_pop   <= take_data;
            if (flow_taken | take_data)
                shift_data <= pick;
        end
    end

endmodule

// File: rtl/txflow_ctrl.sv
// Transmit flow control command unit (top).
// Gates TxFIFO-to-shifter transfers and inserts Xon/Xoff characters on
// host command for one channel.
// Assumes: show-ahead FIFO; shifter busy follows a load by one cycle.
module txflow_ctrl
    import txf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_code,
    input  logic              auto_tx_mode,
    input  logic [DATA_W-1:0] xon_char,
    input  logic [DATA_W-1:0] xoff_char,
    input  logic              fifo_nonempty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic              shifter_busy,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data
);

    txf_op_t    op;
    flow_kind_e pend_kind;
    logic       halt_q;
    logic       flow_taken;

    txf_cmd_decode u_dec (
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .auto_tx_mode (auto_tx_mode),
        .op           (op)
    );

    txf_flow_queue u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .flow_taken (flow_taken),
        .pend_kind  (pend_kind)
    );

    txf_halt_ctrl u_halt (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .halt_q (halt_q)
    );

    txf_load_arb #(.DATA_W(DATA_W)) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_kind     (pend_kind),
        .halt_q        (halt_q),
        .fifo_nonempty (fifo_nonempty),
        .fifo_data     (fifo_data),
        .xon_char      (xon_char),
        .xoff_char     (xoff_char),
        .shifter_busy  (shifter_busy),
        .flow_taken    (flow_taken),
        .shift_load    (shift_load),
        .shift_data    (shift_data),
        .fifo_pop      (fifo_pop)
    );

endmodule

// File: rtl/txf_checker.sv
// Assertion checker for txflow_ctrl, bound to every instance.
module txf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [4:0] cmd_code,
    input logic       shifter_busy,
    input logic       shift_load,
    input logic       fifo_pop,
    input logic [1:0] pend_kind,
    input logic       halt_q
);

    // R10: load strobe is a single-cycle pulse
    a_r10_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |=> !shift_load);

    // R10: a pop only accompanies a load
    a_r10_pop_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> shift_load);

    // R10: no load decided while the shifter reported busy
    a_r10_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        shifter_busy |=> !shift_load);

    // R5: halted state never lets FIFO data through
    a_r5_halt_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q && !(cmd_valid && cmd_code == 5'b10101) |=> !fifo_pop);

    // R4: a pending flow character is never passed over by FIFO data
    a_r4_flow_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind != 2'd0) |=> !fifo_pop);

    // R8: withdraw with no concurrent queueing leaves nothing pending
    a_r8_withdraw_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 5'b10111 |=> pend_kind == 2'd0);

endmodule

bind txflow_ctrl txf_checker u_txf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .shifter_busy (shifter_busy),
    .shift_load   (shift_load),
    .fifo_pop     (fifo_pop),
    .pend_kind    (pend_kind),
    .halt_q       (halt_q)
);

// File: tb/tb_txflow_ctrl.sv
module tb_txflow_ctrl;

    localparam int DATA_W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [4:0]        cmd_code = '0;
    logic              auto_tx_mode = 1'b0;
    logic [DATA_W-1:0] xon_char = 8'h11;
    logic [DATA_W-1:0] xoff_char = 8'h13;
    logic              fifo_nonempty = 1'b0;
    logic [DATA_W-1:0] fifo_data = '0;
    logic              fifo_pop;
    logic              shifter_busy = 1'b0;
    logic              shift_load;
    logic [DATA_W-1:0] shift_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state: 0 none, 1 Xon, 2 Xoff pending
    int m_pend = 0;
    bit m_halt = 0;
    bit m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txflow_ctrl #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .auto_tx_mode(auto_tx_mode), .xon_char(xon_char), .xoff_char(xoff_char),
        .fifo_nonempty(fifo_nonempty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .shifter_busy(shifter_busy), .shift_load(shift_load), .shift_data(shift_data)
    );

    function automatic bit exp_load_f(int pend, bit halt, bit prev, bit busy, bit ne);
        return !busy && !prev && (pend != 0 || (!halt && ne));
    endfunction

    function automatic logic [DATA_W-1:0] exp_data_f(int pend, logic [DATA_W-1:0] on,
                                                     logic [DATA_W-1:0] off,
                                                     logic [DATA_W-1:0] fd);
        return (pend == 1) ? on : (pend == 2) ? off : fd;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: predict, clock, compare, update model. Called at negedge.
    task automatic step(string tag);
        bit               el, ep;
        logic [DATA_W-1:0] ed;
        el = exp_load_f(m_pend, m_halt, m_prev, shifter_busy, fifo_nonempty);
        ep = el && m_pend == 0;
        ed = exp_data_f(m_pend, xon_char, xoff_char, fifo_data);
        if (el && m_pend != 0) m_pend = 0;
        if (cmd_valid) begin
            case (cmd_code)
                5'b01111: m_pend = 1;
                5'b10000: m_pend = 2;
                5'b10111: m_pend = 0;
                5'b10110: m_halt = 1;
                5'b10101: if (!auto_tx_mode) m_halt = 0;
                default: ;
            endcase
        end
        m_prev = el;
        @(posedge clk);
        #1;
        check(tag, "shift_load", int'(shift_load), int'(el));
        check(tag, "fifo_pop", int'(fifo_pop), int'(ep));
        if (el) check(tag, "shift_data", int'(shift_data), int'(ed));
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic cmd(logic [4:0] c);
        cmd_valid = 1'b1;
        cmd_code = c;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        check("R1", "shift_load", int'(shift_load), 0);
        check("R1", "fifo_pop", int'(fifo_pop), 0);
        @(negedge clk);
        rst_n = 1'b1;
        m_pend = 0; m_halt = 0; m_prev = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        do_reset();

        // R2: Xon queued and sent
        cmd(5'b01111); step("R2");
        step("R2"); step("R2"); step("R2");
        // R3: Xoff queued and sent
        cmd(5'b10000); step("R3");
        step("R3"); step("R3");

        // R4: flow character ahead of FIFO data
        shifter_busy = 1; fifo_nonempty = 1; fifo_data = 8'hA5;
        cmd(5'b01111); step("R4"); step("R4");
        shifter_busy = 0; step("R4"); step("R4"); step("R4");

        // R5: halt stops FIFO data
        cmd(5'b10110); step("R5");
        for (int i = 0; i < 5; i++) step("R5");
        // R6: flow character still goes out while halted
        cmd(5'b10000); step("R6"); step("R6"); step("R6");
        // R11: reserved codes and unstrobed codes ignored
        cmd(5'b10100); step("R11");
        cmd(5'b11111); step("R11");
        cmd_code = 5'b10101; step("R11"); step("R11"); step("R11");
        // R7: resume ignored in auto mode, honoured otherwise
        auto_tx_mode = 1; cmd(5'b10101); step("R7"); step("R7"); step("R7");
        auto_tx_mode = 0; cmd(5'b10101); step("R7"); step("R7"); step("R7");

        // R8: withdraw before load
        fifo_nonempty = 0; shifter_busy = 1;
        cmd(5'b01111); step("R8");
        cmd(5'b10111); step("R8");
        shifter_busy = 0; step("R8"); step("R8");
        // R8: withdraw with nothing pending
        cmd(5'b10111); step("R8"); step("R8");
        // R8: withdraw at the same edge as the load
        shifter_busy = 1; cmd(5'b10000); step("R8");
        shifter_busy = 0; cmd(5'b10111); step("R8"); step("R8");

        // R9: newer command replaces the pending one
        shifter_busy = 1; cmd(5'b01111); step("R9");
        cmd(5'b10000); step("R9");
        shifter_busy = 0; step("R9"); step("R9");

        // R1: reset clears pending character and halt
        shifter_busy = 1; cmd(5'b01111); step("R1");
        cmd(5'b10110); step("R1");
        do_reset();
        shifter_busy = 0; fifo_nonempty = 1; fifo_data = 8'h3C;
        step("R1"); step("R1");

        // R10: constrained random mix
        for (int i = 0; i < RAND_CYCLES; i++) begin
            shifter_busy  = ($urandom % 4) == 0;
            fifo_nonempty = ($urandom % 3) != 0;
            fifo_data     = DATA_W'($urandom);
            xon_char      = DATA_W'($urandom);
            xoff_char     = DATA_W'($urandom);
            if (($urandom % 50) == 0) auto_tx_mode = ~auto_tx_mode;
            if (($urandom % 5) == 0) begin
                case ($urandom % 7)
                    0: cmd(5'b01111);
                    1: cmd(5'b10000);
                    2: cmd(5'b10101);
                    3: cmd(5'b10110);
                    4: cmd(5'b10111);
                    default: cmd(5'($urandom));
                endcase
            end
            step("R10");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule